// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit holds the two interrupt status words of a memory-card host controller and one mask register for each word. Short event pulses from the command and data engines (response received, transfer finished, the error conditions) set sticky flags. The buffer logic supplies levels, and the unit turns each rising edge of those levels into a flag. A raw card-detect line is synchronised inside the unit, and its edges become insert and remove flags. Three bits show live line states and are not latched: the synchronised card-detect level, command-in-progress, and the data line 0 level.

Software reads the words through a small register port. It clears flags by writing zero to their positions. A bit written as one keeps its value. One interrupt line is driven high while any sticky flag is set and its mask bit is 0. Software must check the command-busy bit before it issues a new command.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, both status words read 0 (when the live inputs are low), both mask registers read all ones, and `irq` is 0.
- R2: A one-cycle pulse sets its sticky flag, and the flag stays set after the pulse ends. Word 1: bit 0 is response done, bit 2 is data done. Word 2: bit 0 index error, bit 1 CRC error, bit 2 end-bit error, bit 3 data timeout, bit 4 illegal write, bit 5 illegal read, bit 6 response timeout, bit 15 illegal access.
- R3: Word 2 bit 8 (read buffer ready) is set on the rising edge of `buf_rd_full`, and bit 9 (write buffer ready) on the rising edge of `buf_wr_empty`. If one of these flags is cleared while its level is still high, it stays 0 until the level falls and rises again.
- R4: A register write with `reg_addr` 0 (word 1) or 1 (word 2) clears every sticky flag at a position where `reg_wdata` is 0 and leaves the flags where it is 1. The write takes effect at the clock edge that samples `reg_we`.
- R5: Word 1 bit 5 shows the synchronised card-detect level. Word 2 bit 14 shows `cmd_active` (command busy) and word 2 bit 7 shows `dat0_level`. These live bits ignore writes.
- R6: `card_detect_raw` passes through a two-flop synchroniser. Word 1 bit 5 follows a change after two clock edges. A rising synchronised level sets word 1 bit 4 (insert) one edge later, and a falling one sets word 1 bit 3 (remove) one edge later.
- R7: The mask registers are at `reg_addr` 2 (word 1) and 3 (word 2), are written in full and read back. `irq` is the OR of all sticky flags whose mask bit is 0.
- R8: If an event sets a flag in the same cycle as a write that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 word 1, 1 word 2, 2 mask 1, 3 mask 2 |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| card_detect_raw | input | 1 | Asynchronous card-present level |
| cmd_active | input | 1 | Command in progress level |
| dat0_level | input | 1 | Data line 0 level |
| buf_rd_full | input | 1 | Read buffer holds a block (level) |
| buf_wr_empty | input | 1 | Write buffer can take a block (level) |
| ev_resp_done | input | 1 | Response received pulse |
| ev_data_done | input | 1 | Data transfer finished pulse |
| ev_err_index | input | 1 | Command index error pulse |
| ev_err_crc | input | 1 | CRC error pulse |
| ev_err_endbit | input | 1 | End-bit error pulse |
| ev_err_data_tmo | input | 1 | Data timeout pulse |
| ev_err_ill_wr | input | 1 | Illegal write pulse |
| ev_err_ill_rd | input | 1 | Illegal read pulse |
| ev_err_resp_tmo | input | 1 | Response timeout pulse |
| ev_err_ill_access | input | 1 | Illegal access pulse |
| irq | output | 1 | Interrupt request |

## Verification
Single pulses, and a run of every error pulse in turn, show whether each flag lands at its own position and stays set. Partial clear writes (zeros at some positions, ones at others) separate a flag that is cleared from one that is kept. A clear written while a buffer level stays high, and then a fall and rise of that level, separate edge-set from level-set behaviour. Card-detect toggles, checked at each clock edge, pin down the synchroniser latency. A clear write and an event pulse in the same cycle check that the set wins. Changing the mask patterns shows whether `irq` follows only flags that are not masked.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  // word 1 positions
  localparam int W1_RESP   = 0;
  localparam int W1_DATA   = 2;
  localparam int W1_REMOVE = 3;
  localparam int W1_INSERT = 4;
  localparam int W1_CD     = 5;

  // word 2 positions
  localparam int W2_IDX    = 0;
  localparam int W2_CRC    = 1;
  localparam int W2_ENDB   = 2;
  localparam int W2_DTO    = 3;
  localparam int W2_ILW    = 4;
  localparam int W2_ILR    = 5;
  localparam int W2_RTO    = 6;
  localparam int W2_DAT0   = 7;
  localparam int W2_RBR    = 8;
  localparam int W2_WBR    = 9;
  localparam int W2_BUSY   = 14;
  localparam int W2_ILA    = 15;

  localparam logic [15:0] STICKY1 = 16'h001D;
  localparam logic [15:0] STICKY2 = 16'h837F;

  typedef enum logic [1:0] {
    SEL_STAT1 = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_MASK1 = 2'd2,
    SEL_MASK2 = 2'd3
  } sdh_sel_e;

endpackage

// File: rtl/sdh_cd_sync.sv
module sdh_cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_raw,
  output logic cd_level,
  output logic cd_rise,
  output logic cd_fall
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [NST-1:0] sync_q;
  logic [NST-1:0] sync_d;
  logic           prev_q;
  logic           prev_d;

  always_comb begin
    sync_d[0] = cd_raw;
    for (int i = 1; i < NST; i++) sync_d[i] = sync_q[i-1];
    prev_d = sync_q[NST-1];
  end

  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign cd_level = sync_q[NST-1];
  assign cd_rise  = cd_level & ~prev_q;
  assign cd_fall  = ~cd_level & prev_q;

  p_cd_edges_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cd_rise && cd_fall));
  p_cd_rise_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cd_rise |=> !cd_rise);
  p_cd_fall_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cd_fall |=> !cd_fall);

endmodule

// File: rtl/sdh_rise_det.sv
module sdh_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & $past(rise)) == '0);

endmodule

// File: rtl/sdh_flag_word.sv
module sdh_flag_word #(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] STICKY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] live_vec,
  input  logic          stat_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] flags_q;
  logic [DW-1:0] flags_d;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] mask_d;
  logic [DW-1:0] set_eff;

  assign set_eff = set_vec & STICKY;

  always_comb begin
    flags_d = flags_q;
    if (stat_we) flags_d = flags_q & wdata;
    flags_d = flags_d | set_eff;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = wdata;
  end

  genvar b;
  generate
    for (b = 0; b < DW; b++) begin : g_bit
      if (STICKY[b]) begin : g_flop
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flags_q[b] <= 1'b0;
          else        flags_q[b] <= flags_d[b];
        end
      end else begin : g_tie
        assign flags_q[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  assign status_o = flags_q | (live_vec & ~STICKY);
  assign mask_o   = mask_q;
  assign irq_o    = |(flags_q & ~mask_q);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && set_eff != '0) |=> ((status_o & $past(set_eff)) == $past(set_eff)));
  p_write_no_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && set_eff == '0) |=> ((flags_q & ~$past(flags_q)) == '0));
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && set_eff == '0) |=> $stable(flags_q));
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_o));

endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CD_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          card_detect_raw,
  input  logic          cmd_active,
  input  logic          dat0_level,
  input  logic          buf_rd_full,
  input  logic          buf_wr_empty,
  input  logic          ev_resp_done,
  input  logic          ev_data_done,
  input  logic          ev_err_index,
  input  logic          ev_err_crc,
  input  logic          ev_err_endbit,
  input  logic          ev_err_data_tmo,
  input  logic          ev_err_ill_wr,
  input  logic          ev_err_ill_rd,
  input  logic          ev_err_resp_tmo,
  input  logic          ev_err_ill_access,
  output logic          irq
);
  localparam logic [DW-1:0] STK1 = DW'(STICKY1);
  localparam logic [DW-1:0] STK2 = DW'(STICKY2);

  logic cd_level, cd_rise, cd_fall;
  logic [1:0] buf_rise;
  logic [DW-1:0] set1, set2, live1, live2;
  logic [DW-1:0] stat1, stat2, mask1, mask2;
  logic irq1, irq2;
  logic we_s1, we_s2, we_m1, we_m2;

  sdh_cd_sync #(.STAGES(CD_STAGES)) u_cd (
    .clk(clk), .rst_n(rst_n), .cd_raw(card_detect_raw),
    .cd_level(cd_level), .cd_rise(cd_rise), .cd_fall(cd_fall)
  );

  sdh_rise_det #(.N(2)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .lvl({buf_wr_empty, buf_rd_full}), .rise(buf_rise)
  );

  always_comb begin
    set1 = '0;
    set1[W1_RESP]   = ev_resp_done;
    set1[W1_DATA]   = ev_data_done;
    set1[W1_REMOVE] = cd_fall;
    set1[W1_INSERT] = cd_rise;
    live1 = '0;
    live1[W1_CD] = cd_level;
  end

  always_comb begin
    set2 = '0;
    set2[W2_IDX]  = ev_err_index;
    set2[W2_CRC]  = ev_err_crc;
    set2[W2_ENDB] = ev_err_endbit;
    set2[W2_DTO]  = ev_err_data_tmo;
    set2[W2_ILW]  = ev_err_ill_wr;
    set2[W2_ILR]  = ev_err_ill_rd;
    set2[W2_RTO]  = ev_err_resp_tmo;
    set2[W2_RBR]  = buf_rise[0];
    set2[W2_WBR]  = buf_rise[1];
    set2[W2_ILA]  = ev_err_ill_access;
    live2 = '0;
    live2[W2_DAT0] = dat0_level;
    live2[W2_BUSY] = cmd_active;
  end

  always_comb begin
    we_s1 = reg_we && (reg_addr == SEL_STAT1);
    we_s2 = reg_we && (reg_addr == SEL_STAT2);
    we_m1 = reg_we && (reg_addr == SEL_MASK1);
    we_m2 = reg_we && (reg_addr == SEL_MASK2);
  end

  sdh_flag_word #(.DW(DW), .STICKY(STK1)) u_w1 (
    .clk(clk), .rst_n(rst_n), .set_vec(set1), .live_vec(live1),
    .stat_we(we_s1), .mask_we(we_m1), .wdata(reg_wdata),
    .status_o(stat1), .mask_o(mask1), .irq_o(irq1)
  );

  sdh_flag_word #(.DW(DW), .STICKY(STK2)) u_w2 (
    .clk(clk), .rst_n(rst_n), .set_vec(set2), .live_vec(live2),
    .stat_we(we_s2), .mask_we(we_m2), .wdata(reg_wdata),
    .status_o(stat2), .mask_o(mask2), .irq_o(irq2)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_STAT1: reg_rdata = stat1;
      SEL_STAT2: reg_rdata = stat2;
      SEL_MASK1: reg_rdata = mask1;
      default:   reg_rdata = mask2;
    endcase
  end

  assign irq = irq1 | irq2;

  p_busy_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SEL_STAT2) |-> (reg_rdata[W2_BUSY] == cmd_active));
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (((stat1 & STK1) != '0) || ((stat2 & STK2) != '0)));

endmodule

// File: tb/sdh_irq_status_bench.sv
module sdh_irq_status_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic card_detect_raw = 1'b0, cmd_active = 1'b0, dat0_level = 1'b0;
  logic buf_rd_full = 1'b0, buf_wr_empty = 1'b0;
  logic ev_resp_done = 1'b0, ev_data_done = 1'b0, ev_err_index = 1'b0;
  logic ev_err_crc = 1'b0, ev_err_endbit = 1'b0, ev_err_data_tmo = 1'b0;
  logic ev_err_ill_wr = 1'b0, ev_err_ill_rd = 1'b0, ev_err_resp_tmo = 1'b0;
  logic ev_err_ill_access = 1'b0;
  logic irq;

  always #2.5 clk = ~clk;

  sdh_irq_status #(.DW(DW)) u_sdh_irq_status (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_detect_raw(card_detect_raw), .cmd_active(cmd_active),
    .dat0_level(dat0_level), .buf_rd_full(buf_rd_full),
    .buf_wr_empty(buf_wr_empty), .ev_resp_done(ev_resp_done),
    .ev_data_done(ev_data_done), .ev_err_index(ev_err_index),
    .ev_err_crc(ev_err_crc), .ev_err_endbit(ev_err_endbit),
    .ev_err_data_tmo(ev_err_data_tmo), .ev_err_ill_wr(ev_err_ill_wr),
    .ev_err_ill_rd(ev_err_ill_rd), .ev_err_resp_tmo(ev_err_resp_tmo),
    .ev_err_ill_access(ev_err_ill_access), .irq(irq)
  );

  typedef struct {
    int          sel;   // 0..3 register, 4 irq
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      total++;
      if (it.sel == 4) begin
        if (irq !== it.exp[0]) begin
          bad++;
          $display("FAIL %s: irq actual=%0b expected=%0b", it.tag, irq, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: reg %0d actual=%h expected=%h", it.tag, it.sel, reg_rdata, it.exp);
      end
    end
  end

  // driver side
  task automatic chk(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    if (sel < 4) reg_addr = 2'(sel);
    #1;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ev(input int which, input logic v);
    case (which)
      0: ev_resp_done = v;
      1: ev_data_done = v;
      2: ev_err_index = v;
      3: ev_err_crc = v;
      4: ev_err_endbit = v;
      5: ev_err_data_tmo = v;
      6: ev_err_ill_wr = v;
      7: ev_err_ill_rd = v;
      8: ev_err_resp_tmo = v;
      default: ev_err_ill_access = v;
    endcase
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    set_ev(which, 1'b1);
    @(negedge clk);
    set_ev(which, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(0, 16'h0000, "R1 word1");
    chk(1, 16'h0000, "R1 word2");
    chk(2, 16'hFFFF, "R1 mask1");
    chk(3, 16'hFFFF, "R1 mask2");
    chk(4, 16'h0000, "R1 irq");

    // R2 response pulse, masked so no irq
    pulse(0);
    @(negedge clk);
    chk(0, 16'h0001, "R2 resp sticky");
    chk(4, 16'h0000, "R7 masked irq");

    // R7 unmask response bit
    wr(2, 16'hFFFE);
    chk(2, 16'hFFFE, "R7 mask1 readback");
    chk(4, 16'h0001, "R7 irq unmasked");

    // R4 partial clear
    pulse(1);
    chk(0, 16'h0005, "R2 data done");
    wr(0, 16'hFFFE);
    chk(0, 16'h0004, "R4 partial clear");
    chk(4, 16'h0000, "R7 irq after clear");
    wr(0, 16'h0000);
    chk(0, 16'h0000, "R4 full clear");

    // R2 every error pulse
    for (int k = 2; k < 10; k++) pulse(k);
    chk(1, 16'h807F, "R2 error flags");

    // R5 live bits
    @(negedge clk);
    cmd_active = 1'b1; dat0_level = 1'b1;
    chk(1, 16'hC0FF, "R5 live bits shown");
    wr(1, 16'h0000);
    chk(1, 16'h4080, "R5 live survive clear");
    wr(1, 16'hFFFF);
    chk(1, 16'h4080, "R4 ones do not set");
    cmd_active = 1'b0; dat0_level = 1'b0;
    chk(1, 16'h0000, "R5 live follow");

    // R3 read buffer edge
    buf_rd_full = 1'b1;
    @(negedge clk);
    chk(1, 16'h0100, "R3 read ready set");
    wr(1, 16'h0000);
    repeat (3) @(negedge clk);
    chk(1, 16'h0000, "R3 stays clear while full");
    buf_rd_full = 1'b0;
    @(negedge clk);
    buf_rd_full = 1'b1;
    @(negedge clk);
    chk(1, 16'h0100, "R3 new edge sets");
    buf_rd_full = 1'b0;
    buf_wr_empty = 1'b1;
    @(negedge clk);
    chk(1, 16'h0300, "R3 write ready set");
    wr(1, 16'h0000);
    @(negedge clk);
    chk(1, 16'h0000, "R3 write ready stays clear");
    buf_wr_empty = 1'b0;

    // R8 set wins over clear
    pulse(2);
    chk(1, 16'h0001, "R8 setup");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0000; ev_err_crc = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ev_err_crc = 1'b0;
    chk(1, 16'h0002, "R8 set wins");

    // R6 card detect
    card_detect_raw = 1'b1;
    @(negedge clk);
    chk(0, 16'h0000, "R6 one edge not yet");
    @(negedge clk);
    chk(0, 16'h0020, "R6 level after two");
    @(negedge clk);
    chk(0, 16'h0030, "R6 insert flag");
    wr(0, 16'h0000);
    chk(0, 16'h0020, "R5 cd ignores write");
    card_detect_raw = 1'b0;
    repeat (2) @(negedge clk);
    chk(0, 16'h0000, "R6 level low");
    @(negedge clk);
    chk(0, 16'h0008, "R6 remove flag");

    // R7 masks and irq
    wr(2, 16'hFFFF);
    chk(4, 16'h0000, "R7 remove masked");
    wr(2, 16'hFFF7);
    chk(4, 16'h0001, "R7 remove unmasked");
    wr(0, 16'h0000);
    wr(1, 16'h0000);
    chk(4, 16'h0000, "R7 no flags");
    wr(3, 16'hFFFD);
    chk(3, 16'hFFFD, "R7 mask2 readback");
    pulse(3);
    chk(4, 16'h0001, "R7 crc unmasked");
    wr(3, 16'hFFFF);
    chk(4, 16'h0000, "R7 crc masked");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule